// File: doc/BRIEF.md
# Register-Compare Branch Resolution Unit

This unit resolves one compare-and-branch instruction per cycle for a 32-bit instruction word that names two source registers and a 15-bit displacement. The register values have already been read by the surrounding pipeline and arrive as operands: two data-register values, two address-register values and a loop-counter value, together with the PC of the instruction. The unit decodes the major opcode and the one-bit sub-operation selector. It evaluates the condition and returns four results one cycle later: whether the branch is taken, the branch target, the next PC, and any register write-back that the counting variants need. Fetch redirection, pipeline flushing and the register file belong to the surrounding pipeline.

The instruction word is laid out as follows:

| Field | Bits |
|---|---|
| Major opcode | 7:0 |
| First register index | 11:8 |
| Second register index | 15:12 |
| Signed displacement | 30:16 |
| Variant selector | 31 |

The result register is controlled by a two-state slot machine. The state S_EMPTY moves to S_FULL on the transition "accept", which happens when `in_vld` is high. The state S_FULL stays in S_FULL on "accept" and returns to S_EMPTY on the transition "drain", which happens when `in_vld` is low. Outputs are meaningful only in S_FULL, which is when `out_vld` is high.

Top module: `brr_resolve_unit`

## Requirements
- R1: A taken branch targets PC plus the displacement (bits 30:16, sign-extended) shifted left by one. Fields: major opcode bits 7:0, first index bits 11:8, second index bits 15:12, selector bit 31.
- R2: Opcode 0x11 compares the two data operands. Selector 0 takes the branch on equal; selector 1 takes it on not-equal.
- R3: Opcode 0x21 compares the two address operands. Selector 0 takes the branch on equal; selector 1 takes it on not-equal.
- R4: Opcode 0x31 takes the branch when data operand 1 is greater than or equal to data operand 2. Selector 0 compares signed; selector 1 compares unsigned.
- R5: Opcode 0x41 takes the branch when data operand 1 is less than data operand 2. Selector 0 compares signed; selector 1 compares unsigned.
- R6: Opcode 0x51 takes the branch when the old data operand 1 differs from data operand 2. Whether or not the branch is taken, it writes back to the first index: operand 1 minus one for selector 0, or plus one for selector 1.
- R7: When the two register indices are equal, every data-register compare uses data operand 1 for both sides. Such a compare therefore sees equal values.
- R8: Opcode 0x61 tests address operand 1. Selector 0 takes the branch when it is non-zero; selector 1 takes it when it is zero.
- R9: Opcode 0x71 with selector 1 is always taken. With selector 0, it is taken when the loop value is non-zero, and it always writes the loop value minus one to the first index.
- R10: Any other opcode raises `out_illegal`, with taken and write-back enable low.
- R11: Results appear the cycle after `in_vld`. `out_next_pc` is the target when taken and PC+4 otherwise. While `out_vld` is low, taken, write-back enable and illegal are low.
- R12: After reset, `out_vld`, `out_taken`, `out_wb_en` and `out_illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| pc | input | AW | PC of the instruction |
| d_src1 | input | DW | Data register named by the first index |
| d_src2 | input | DW | Data register named by the second index |
| a_src1 | input | AW | Address register named by the first index |
| a_src2 | input | AW | Address register named by the second index |
| loop_val | input | DW | Loop-counter register value |
| out_vld | output | 1 | Result slot is full |
| out_taken | output | 1 | Branch is taken |
| out_target | output | AW | Branch target address |
| out_next_pc | output | AW | Target if taken, PC+4 otherwise |
| out_wb_en | output | 1 | Register write-back requested |
| out_wb_idx | output | 4 | Index of the register to write |
| out_wb_data | output | DW | Value to write |
| out_illegal | output | 1 | Major opcode not recognised |

## Verification
Every result is due exactly one clock edge after the cycle in which `in_vld` was high. The driver applies each instruction on a falling edge and pushes the expected result into a queue at the same time. The monitor samples on the following falling edge, so only one rising edge lies between stimulus and check. It pops and compares only while `out_vld` is high, which keeps back-to-back instructions matched in order. A deliberate idle gap confirms that the flags drop the cycle after `in_vld` falls.

// File: rtl/brr_pkg.sv
package brr_pkg;

    localparam logic [7:0] OPC_DEQ   = 8'h11;
    localparam logic [7:0] OPC_AEQ   = 8'h21;
    localparam logic [7:0] OPC_GE    = 8'h31;
    localparam logic [7:0] OPC_LT    = 8'h41;
    localparam logic [7:0] OPC_NEMOD = 8'h51;
    localparam logic [7:0] OPC_AZ    = 8'h61;
    localparam logic [7:0] OPC_LOOP  = 8'h71;

    typedef enum logic [0:0] {
        S_EMPTY = 1'b0,
        S_FULL  = 1'b1
    } slot_state_e;

    typedef struct packed {
        logic        sel;
        logic [14:0] disp;
        logic [3:0]  idx2;
        logic [3:0]  idx1;
        logic [7:0]  opc;
    } brr_fields_t;

endpackage

// File: rtl/brr_field_decode.sv
module brr_field_decode
    import brr_pkg::*;
(
    input  logic [31:0] instr,
    output brr_fields_t fld
);
    always_comb begin
        fld.opc  = instr[7:0];
        fld.idx1 = instr[11:8];
        fld.idx2 = instr[15:12];
        fld.disp = instr[30:16];
        fld.sel  = instr[31];
    end
endmodule

// File: rtl/brr_cond_eval.sv
module brr_cond_eval
    import brr_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  brr_fields_t     fld,
    input  logic [DW-1:0]   d_src1,
    input  logic [DW-1:0]   d_src2,
    input  logic [AW-1:0]   a_src1,
    input  logic [AW-1:0]   a_src2,
    input  logic [DW-1:0]   loop_val,
    output logic            take,
    output logic            wb_en,
    output logic [DW-1:0]   wb_data,
    output logic            illegal
);
    localparam logic [DW-1:0] ONE = DW'(1);

    logic [DW-1:0] cmp_rhs;

    // same index on both sides: both read the first operand
    assign cmp_rhs = (fld.idx1 == fld.idx2) ? d_src1 : d_src2;

    always_comb begin
        take    = 1'b0;
        wb_en   = 1'b0;
        wb_data = '0;
        illegal = 1'b0;
        unique case (fld.opc)
            OPC_DEQ:   take = fld.sel ? (d_src1 != cmp_rhs) : (d_src1 == cmp_rhs);
            OPC_AEQ:   take = fld.sel ? (a_src1 != a_src2) : (a_src1 == a_src2);
            OPC_GE:    take = fld.sel ? ($unsigned(d_src1) >= $unsigned(cmp_rhs))
                                      : ($signed(d_src1) >= $signed(cmp_rhs));
            OPC_LT:    take = fld.sel ? ($unsigned(d_src1) < $unsigned(cmp_rhs))
                                      : ($signed(d_src1) < $signed(cmp_rhs));
            OPC_NEMOD: begin
                take    = (d_src1 != cmp_rhs);
                wb_en   = 1'b1;
                wb_data = fld.sel ? (d_src1 + ONE) : (d_src1 - ONE);
            end
            OPC_AZ:    take = fld.sel ? (a_src1 == '0) : (a_src1 != '0);
            OPC_LOOP: begin
                if (fld.sel) begin
                    take = 1'b1;
                end else begin
                    take    = (loop_val != '0);
                    wb_en   = 1'b1;
                    wb_data = loop_val - ONE;
                end
            end
            default:   illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/brr_target_calc.sv
module brr_target_calc #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] pc,
    input  logic [14:0]   disp,
    input  logic          take,
    output logic [AW-1:0] target,
    output logic [AW-1:0] next_pc
);
    localparam int SEXT_W = AW - 16;

    logic [AW-1:0] offset;

    assign offset  = {{SEXT_W{disp[14]}}, disp, 1'b0};
    assign target  = pc + offset;
    assign next_pc = take ? target : (pc + AW'(4));
endmodule

// File: rtl/brr_resolve_unit.sv
module brr_resolve_unit
    import brr_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [31:0]     instr,
    input  logic [AW-1:0]   pc,
    input  logic [DW-1:0]   d_src1,
    input  logic [DW-1:0]   d_src2,
    input  logic [AW-1:0]   a_src1,
    input  logic [AW-1:0]   a_src2,
    input  logic [DW-1:0]   loop_val,
    output logic            out_vld,
    output logic            out_taken,
    output logic [AW-1:0]   out_target,
    output logic [AW-1:0]   out_next_pc,
    output logic            out_wb_en,
    output logic [3:0]      out_wb_idx,
    output logic [DW-1:0]   out_wb_data,
    output logic            out_illegal
);
    brr_fields_t   fld;
    logic          c_take, c_wb_en, c_illegal;
    logic [DW-1:0] c_wb_data;
    logic [AW-1:0] c_target, c_next_pc;
    slot_state_e   state_q, state_d;

    brr_field_decode u_dec (
        .instr (instr),
        .fld   (fld)
    );

    brr_cond_eval #(.DW(DW), .AW(AW)) u_eval (
        .fld      (fld),
        .d_src1   (d_src1),
        .d_src2   (d_src2),
        .a_src1   (a_src1),
        .a_src2   (a_src2),
        .loop_val (loop_val),
        .take     (c_take),
        .wb_en    (c_wb_en),
        .wb_data  (c_wb_data),
        .illegal  (c_illegal)
    );

    brr_target_calc #(.AW(AW)) u_tgt (
        .pc      (pc),
        .disp    (fld.disp),
        .take    (c_take),
        .target  (c_target),
        .next_pc (c_next_pc)
    );

    always_comb begin
        unique case (state_q)
            S_EMPTY: state_d = in_vld ? S_FULL : S_EMPTY;
            S_FULL:  state_d = in_vld ? S_FULL : S_EMPTY;
            default: state_d = S_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_taken   <= 1'b0;
            out_wb_en   <= 1'b0;
            out_illegal <= 1'b0;
            out_target  <= '0;
            out_next_pc <= '0;
            out_wb_idx  <= '0;
            out_wb_data <= '0;
        end else if (in_vld) begin
            out_taken   <= c_take;
            out_wb_en   <= c_wb_en;
            out_illegal <= c_illegal;
            out_target  <= c_target;
            out_next_pc <= c_next_pc;
            out_wb_idx  <= fld.idx1;
            out_wb_data <= c_wb_data;
        end else begin
            out_taken   <= 1'b0;
            out_wb_en   <= 1'b0;
            out_illegal <= 1'b0;
        end
    end

    assign out_vld = (state_q == S_FULL);
endmodule

// File: rtl/brr_resolve_chk.sv
module brr_resolve_chk
    import brr_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_vld,
    input logic [31:0]     instr,
    input logic [AW-1:0]   pc,
    input logic [DW-1:0]   d_src1,
    input logic            out_vld,
    input logic            out_taken,
    input logic [AW-1:0]   out_next_pc,
    input logic            out_wb_en,
    input logic [DW-1:0]   out_wb_data,
    input logic            out_illegal
);
    p_vld_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (!out_taken && !out_wb_en && !out_illegal));

    p_fallthrough_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (out_taken || out_next_pc == $past(pc) + AW'(4)));

    p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (!out_taken && !out_wb_en));

    p_modify_always_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && instr[7:0] == OPC_NEMOD) |=>
        (out_wb_en && out_wb_data == ($past(instr[31]) ? $past(d_src1) + DW'(1)
                                                       : $past(d_src1) - DW'(1))));

    p_uncond_loop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && instr[7:0] == OPC_LOOP && instr[31]) |=> out_taken);
endmodule

bind brr_resolve_unit brr_resolve_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_vld      (in_vld),
    .instr       (instr),
    .pc          (pc),
    .d_src1      (d_src1),
    .out_vld     (out_vld),
    .out_taken   (out_taken),
    .out_next_pc (out_next_pc),
    .out_wb_en   (out_wb_en),
    .out_wb_data (out_wb_data),
    .out_illegal (out_illegal)
);

// File: tb/tb_brr_resolve_unit.sv
module tb_brr_resolve_unit;
    localparam int DW = 32;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld = 1'b0;
    logic [31:0]   instr = '0;
    logic [AW-1:0] pc = '0;
    logic [DW-1:0] d_src1 = '0, d_src2 = '0, loop_val = '0;
    logic [AW-1:0] a_src1 = '0, a_src2 = '0;
    logic          out_vld, out_taken, out_wb_en, out_illegal;
    logic [AW-1:0] out_target, out_next_pc;
    logic [3:0]    out_wb_idx;
    logic [DW-1:0] out_wb_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic          taken;
        logic [AW-1:0] next_pc;
        logic          wb_en;
        logic [3:0]    wb_idx;
        logic [DW-1:0] wb_data;
        logic          illegal;
        string         req;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    brr_resolve_unit #(.DW(DW), .AW(AW)) dut (.*);

    function automatic logic [31:0] mk(input logic [7:0] opc, input logic sel,
                                       input logic [14:0] disp,
                                       input logic [3:0] r1, input logic [3:0] r2);
        return {sel, disp, r2, r1, opc};
    endfunction

    task automatic send(input logic [31:0] ins, input logic [AW-1:0] p,
                        input logic [DW-1:0] da, input logic [DW-1:0] db,
                        input logic [AW-1:0] aa, input logic [AW-1:0] ab,
                        input logic [DW-1:0] lc, input string req);
        exp_t e;
        logic [DW-1:0] rhs;
        logic [AW-1:0] tgt;
        logic sel;
        sel = ins[31];
        rhs = (ins[11:8] == ins[15:12]) ? da : db;
        tgt = p + {{(AW-16){ins[30]}}, ins[30:16], 1'b0};
        e.taken = 0; e.wb_en = 0; e.wb_data = 0; e.illegal = 0;
        e.wb_idx = ins[11:8]; e.req = req;
        case (ins[7:0])
            8'h11: e.taken = sel ? (da != rhs) : (da == rhs);
            8'h21: e.taken = sel ? (aa != ab) : (aa == ab);
            8'h31: e.taken = sel ? (da >= rhs) : ($signed(da) >= $signed(rhs));
            8'h41: e.taken = sel ? (da < rhs) : ($signed(da) < $signed(rhs));
            8'h51: begin e.taken = (da != rhs); e.wb_en = 1;
                         e.wb_data = sel ? da + 1 : da - 1; end
            8'h61: e.taken = sel ? (aa == 0) : (aa != 0);
            8'h71: if (sel) e.taken = 1;
                   else begin e.taken = (lc != 0); e.wb_en = 1; e.wb_data = lc - 1; end
            default: e.illegal = 1;
        endcase
        e.next_pc = e.taken ? tgt : p + 4;
        @(negedge clk);
        in_vld = 1; instr = ins; pc = p;
        d_src1 = da; d_src2 = db; a_src1 = aa; a_src2 = ab; loop_val = lc;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_vld = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R11 unexpected result: actual out_vld=1 expected no result");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (out_taken !== e.taken || out_next_pc !== e.next_pc ||
                    out_wb_en !== e.wb_en || out_illegal !== e.illegal ||
                    (e.wb_en && (out_wb_idx !== e.wb_idx || out_wb_data !== e.wb_data))) begin
                    fails++;
                    $display("FAIL %s actual t=%0b npc=%h wb=%0b/%0d/%h ill=%0b expected t=%0b npc=%h wb=%0b/%0d/%h ill=%0b",
                             e.req, out_taken, out_next_pc, out_wb_en, out_wb_idx, out_wb_data,
                             out_illegal, e.taken, e.next_pc, e.wb_en, e.wb_idx, e.wb_data, e.illegal);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;  // R12 reset state
        if (out_vld !== 0 || out_taken !== 0 || out_wb_en !== 0 || out_illegal !== 0) begin
            fails++;
            $display("FAIL R12 reset: actual vld=%0b t=%0b wb=%0b ill=%0b expected all 0",
                     out_vld, out_taken, out_wb_en, out_illegal);
        end
        rst_n = 1;
        // R1 R2 data equality
        send(mk(8'h11, 0, 15'd8, 4'd1, 4'd2), 32'h1000, 7, 7, 0, 0, 0, "R1 R2 eq taken");
        send(mk(8'h11, 1, 15'd8, 4'd1, 4'd2), 32'h1000, 7, 7, 0, 0, 0, "R2 ne not taken");
        send(mk(8'h11, 1, 15'h7ff0, 4'd1, 4'd2), 32'h2000, 7, 9, 0, 0, 0, "R1 R2 ne neg disp");
        // R7 same index aliases
        send(mk(8'h11, 0, 15'd4, 4'd3, 4'd3), 32'h3000, 5, 6, 0, 0, 0, "R7 eq same idx");
        // R3 address equality
        send(mk(8'h21, 0, 15'd2, 4'd1, 4'd2), 32'h4000, 0, 0, 32'hA0, 32'hA4, 0, "R3 aeq");
        send(mk(8'h21, 1, 15'd2, 4'd1, 4'd2), 32'h4000, 0, 0, 32'hA0, 32'hA4, 0, "R3 ane");
        // R4 R5 signedness
        send(mk(8'h31, 0, 15'd6, 4'd1, 4'd2), 32'h5000, 32'hFFFF_FFFF, 1, 0, 0, 0, "R4 ge signed");
        send(mk(8'h31, 1, 15'd6, 4'd1, 4'd2), 32'h5000, 32'hFFFF_FFFF, 1, 0, 0, 0, "R4 ge unsigned");
        send(mk(8'h41, 0, 15'd6, 4'd1, 4'd2), 32'h5000, 32'hFFFF_FFFF, 1, 0, 0, 0, "R5 lt signed");
        send(mk(8'h41, 1, 15'd6, 4'd1, 4'd2), 32'h5000, 32'hFFFF_FFFF, 1, 0, 0, 0, "R5 lt unsigned");
        // R6 modify variants
        send(mk(8'h51, 0, 15'h7ffe, 4'd4, 4'd5), 32'h6000, 5, 5, 0, 0, 0, "R6 dec not taken");
        send(mk(8'h51, 1, 15'h7ffe, 4'd4, 4'd5), 32'h6000, 5, 7, 0, 0, 0, "R6 inc taken");
        send(mk(8'h51, 0, 15'd10, 4'd6, 4'd6), 32'h6100, 3, 9, 0, 0, 0, "R7 dec same idx");
        // R8 address zero
        send(mk(8'h61, 0, 15'd3, 4'd1, 4'd0), 32'h7000, 0, 0, 0, 5, 0, "R8 nz on zero");
        send(mk(8'h61, 1, 15'd3, 4'd1, 4'd0), 32'h7000, 0, 0, 0, 5, 0, "R8 z on zero");
        send(mk(8'h61, 0, 15'd3, 4'd1, 4'd0), 32'h7000, 0, 0, 32'h10, 0, 0, "R8 nz on nonzero");
        // R9 loops
        send(mk(8'h71, 1, 15'h7ff8, 4'd2, 4'd0), 32'h8000, 0, 0, 0, 0, 0, "R9 uncond loop");
        send(mk(8'h71, 0, 15'h7ff8, 4'd2, 4'd0), 32'h8000, 0, 0, 0, 0, 0, "R9 counted zero");
        send(mk(8'h71, 0, 15'h7ff8, 4'd2, 4'd0), 32'h8000, 0, 0, 0, 0, 3, "R9 counted three");
        // R10 illegal
        send(mk(8'h00, 0, 15'd1, 4'd1, 4'd2), 32'h9000, 1, 1, 0, 0, 0, "R10 illegal");
        idle();
        @(negedge clk);
        checks++;  // R11 idle flags low
        if (out_vld !== 0 || out_taken !== 0 || out_wb_en !== 0 || out_illegal !== 0) begin
            fails++;
            $display("FAIL R11 idle: actual vld=%0b t=%0b wb=%0b ill=%0b expected all 0",
                     out_vld, out_taken, out_wb_en, out_illegal);
        end
        checks++;  // R11 every pushed result produced
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R11 missing results: actual %0d pending expected 0", sb.size());
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule